// File: doc/BRIEF.md
# Subaddressed I2C Register Slave

This block is an I2C-bus target that lets an external controller reach a small bank of control registers. It answers to one fixed 7-bit device address. The first byte after a write-addressed frame is a subaddress that picks a register. Each register has a fixed width of one or two bytes. A two-byte register moves most significant byte first. A read starts by writing the subaddress. It then issues a repeated start with the read bit set and clocks out the bytes.

Both bus lines are sampled through a synchronizer on the system clock. Start and stop conditions, address match, acknowledge and data transfer all run from the sampled edges. The block drives each line low only, never high. It answers a bad subaddress or a surplus data byte with NAK.

Reads fetch from the register bank over an internal request/response pair. The fetch has a fixed latency. While a byte is being fetched, the block holds SCL low. That stretched clock is the back-pressure path: the master cannot start the next byte until the data is valid, and the bank never sees a second request while one is in flight.

Top module: `i2c_regslave`

## Requirements
- R1: A frame whose first byte is 0x8A (device address 0x45 with R/W = 0) or 0x8B (R/W = 1) is acknowledged. R/W = 0 selects a write and R/W = 1 selects a read.
- R2: Any other address byte gets no acknowledge. The block then leaves SDA released for all further bytes until the next start condition.
- R3: Subaddresses 0x00 and 0x01 are one-byte registers and 0x10 and 0x11 are two-byte registers. Any other subaddress is NAKed, and so is every byte after it.
- R4: A one-byte write to a one-byte register stores the byte, and a later read returns it.
- R5: A two-byte register is written and read high byte first, then low byte.
- R6: A two-byte write is stored only once the second data byte has been acknowledged. A stop after the first data byte leaves the old value intact.
- R7: A data byte beyond the width of the selected register is NAKed and changes nothing.
- R8: A read returns bytes from the subaddress latched earlier in the frame. Bytes past the register width read as 0xFF. A master NAK ends the transfer.
- R9: Before every returned byte the block holds SCL low for at least RD_LAT system clocks, until the fetched byte is valid.
- R10: A stop condition releases both lines. A start condition restarts address framing from any state, and a write after a repeated start is honoured.
- R11: After reset both lines are released and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | When 1, the open-drain SCL driver pulls low (clock stretch) |
| sda_drive_low | output | 1 | When 1, the open-drain SDA driver pulls low (ACK or a zero data bit) |

## Verification
The bench writes a one-byte register and then sends a surplus second byte. A design without a per-register width would acknowledge that byte and overwrite the register. A two-byte write cut short by a stop checks that the high byte is not committed on its own. Reading past the end of a two-byte register must return 0xFF, not wrap to the high byte. An unknown address and an unknown subaddress must each leave SDA released for the rest of the frame. The bench counts stretch episodes against the bytes received, and it checks that each stretch lasts at least the fetch latency. A design that released SCL early would hand out a stale byte.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDAT,
    ST_ACK,
    ST_FETCH,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } rs_state_e;

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_p, sda_p;
  logic scl_d, sda_d, scl_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-2:0], scl_i};
      sda_p <= {sda_p[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_p[SYNC_STAGES-1];
      sda_d <= sda_p[SYNC_STAGES-1];
    end
  end

  assign scl_n     = scl_p[SYNC_STAGES-1];
  assign sda_s     = sda_p[SYNC_STAGES-1];
  assign scl_rise  = scl_n & ~scl_d;
  assign scl_fall  = ~scl_n & scl_d;
  // SDA moving while SCL stays high frames the transfer
  assign start_det = scl_n & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_n & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rs_regs.sv
module i2c_rs_regs #(
  parameter int          N8     = 2,
  parameter int          N16    = 2,
  parameter logic [7:0]  BASE16 = 8'h10,
  parameter int          RD_LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  chk_sub,
  output logic        chk_ok,
  output logic        chk_wide,
  input  logic        wr_en,
  input  logic [7:0]  wr_sub,
  input  logic [15:0] wr_data,
  input  logic        rd_req,
  input  logic [7:0]  rd_sub,
  input  logic [1:0]  rd_idx,
  output logic        rd_valid,
  output logic [7:0]  rd_byte
);

  localparam int LW = $clog2(RD_LAT + 1);

  logic [N8-1:0][7:0]   r8v;
  logic [N16-1:0][15:0] r16v;
  logic [7:0]           sel;
  logic [7:0]           hold_q;
  logic [LW-1:0]        lat_cnt;
  logic                 narrow_hit, wide_hit;

  for (genvar g = 0; g < N8; g++) begin : g_r8
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= '0;
      else if (wr_en && wr_sub == 8'(g))     q <= wr_data[7:0];
    end
    assign r8v[g] = q;
  end

  for (genvar g = 0; g < N16; g++) begin : g_r16
    logic [15:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_en && wr_sub == 8'(BASE16 + g)) q <= wr_data;
    end
    assign r16v[g] = q;
  end

  // width table: which subaddresses exist and how many bytes each carries
  always_comb begin
    narrow_hit = 1'b0;
    wide_hit   = 1'b0;
    for (int i = 0; i < N8; i++)
      if (chk_sub == 8'(i)) narrow_hit = 1'b1;
    for (int i = 0; i < N16; i++)
      if (chk_sub == 8'(BASE16 + i)) wide_hit = 1'b1;
  end
  assign chk_ok   = narrow_hit | wide_hit;
  assign chk_wide = wide_hit;

  always_comb begin
    sel = 8'hFF;
    for (int i = 0; i < N8; i++)
      if (rd_sub == 8'(i) && rd_idx == 2'd0) sel = r8v[i];
    for (int i = 0; i < N16; i++) begin
      if (rd_sub == 8'(BASE16 + i) && rd_idx == 2'd0) sel = r16v[i][15:8];
      if (rd_sub == 8'(BASE16 + i) && rd_idx == 2'd1) sel = r16v[i][7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      lat_cnt  <= '0;
      rd_valid <= 1'b0;
    end else if (rd_req) begin
      hold_q   <= sel;
      lat_cnt  <= LW'(RD_LAT);
      rd_valid <= 1'b0;
    end else if (lat_cnt != '0) begin
      lat_cnt  <= lat_cnt - LW'(1);
      rd_valid <= (lat_cnt == LW'(1));
    end else begin
      rd_valid <= 1'b0;
    end
  end

  assign rd_byte = hold_q;

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h45
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  output logic [7:0]  chk_sub,
  input  logic        chk_ok,
  input  logic        chk_wide,
  output logic        wr_en,
  output logic [7:0]  wr_sub,
  output logic [15:0] wr_data,
  output logic        rd_req,
  output logic [7:0]  rd_sub,
  output logic [1:0]  rd_idx,
  input  logic        rd_valid,
  input  logic [7:0]  rd_byte,
  output logic        sda_oe,
  output logic        scl_oe
);

  rs_state_e  state, nxt_q;
  logic [3:0] cnt;
  logic [7:0] sh, sub, hi;
  logic [1:0] bidx;
  logic       wide, pend_wr, mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  nxt_q <= ST_IDLE;
      cnt <= '0;  sh <= '0;  sub <= '0;  hi <= '0;  bidx <= '0;
      wide <= 1'b0;  pend_wr <= 1'b0;  mack <= 1'b0;
      wr_en <= 1'b0;  wr_data <= '0;  rd_req <= 1'b0;
      sda_oe <= 1'b0;  scl_oe <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;  cnt <= '0;  pend_wr <= 1'b0;
        sda_oe <= 1'b0;  scl_oe <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;  pend_wr <= 1'b0;
        sda_oe <= 1'b0;  scl_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_SUB, ST_WDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;  state <= ST_ACK;  bidx <= '0;
                  nxt_q  <= sh[0] ? ST_FETCH : ST_SUB;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                state  <= ST_ACK;
                sda_oe <= chk_ok;
                if (chk_ok) begin
                  sub <= sh;  wide <= chk_wide;  bidx <= '0;  nxt_q <= ST_WDAT;
                end else begin
                  nxt_q <= ST_SKIP;
                end
              end else begin
                state <= ST_ACK;
                if (bidx == 2'd0 || (wide && bidx == 2'd1)) begin
                  sda_oe <= 1'b1;  nxt_q <= ST_WDAT;  bidx <= bidx + 2'd1;
                  if (wide && bidx == 2'd0) hi <= sh;
                  else begin
                    pend_wr <= 1'b1;
                    wr_data <= wide ? {hi, sh} : {8'h00, sh};
                  end
                end else begin
                  sda_oe <= 1'b0;  nxt_q <= ST_SKIP;
                end
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= nxt_q;
            if (pend_wr) begin wr_en <= 1'b1; pend_wr <= 1'b0; end
            if (nxt_q == ST_FETCH) begin rd_req <= 1'b1; scl_oe <= 1'b1; end
          end
          ST_FETCH: if (rd_valid) begin
            sh <= rd_byte;  sda_oe <= ~rd_byte[7];
            scl_oe <= 1'b0;  cnt <= '0;  state <= ST_TX;
          end
          ST_TX: if (scl_fall) begin
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;  state <= ST_MACK;
            end else begin
              sda_oe <= ~sh[6];  sh <= {sh[6:0], 1'b0};
            end
          end
          ST_MACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                if (bidx != 2'd3) bidx <= bidx + 2'd1;
                rd_req <= 1'b1;  scl_oe <= 1'b1;  state <= ST_FETCH;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign chk_sub = sh;
  assign wr_sub  = sub;
  assign rd_sub  = sub;
  assign rd_idx  = bidx;

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ADDR    = 7'h45,
  parameter int         N8          = 2,
  parameter int         N16         = 2,
  parameter logic [7:0] BASE16      = 8'h10,
  parameter int         RD_LAT      = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_drive_low,
  output logic sda_drive_low
);

  logic        sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0]  chk_sub, wr_sub, rd_sub, rd_byte;
  logic        chk_ok, chk_wide, wr_en, rd_req, rd_valid;
  logic [15:0] wr_data;
  logic [1:0]  rd_idx;

  i2c_rs_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_rs_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .chk_sub(chk_sub), .chk_ok(chk_ok), .chk_wide(chk_wide),
    .wr_en(wr_en), .wr_sub(wr_sub), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sub(rd_sub), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_byte(rd_byte),
    .sda_oe(sda_drive_low), .scl_oe(scl_drive_low)
  );

  i2c_rs_regs #(.N8(N8), .N16(N16), .BASE16(BASE16), .RD_LAT(RD_LAT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .chk_sub(chk_sub), .chk_ok(chk_ok), .chk_wide(chk_wide),
    .wr_en(wr_en), .wr_sub(wr_sub), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sub(rd_sub), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_byte(rd_byte)
  );

endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_drive_low,
  input logic sda_drive_low,
  input logic start_det,
  input logic stop_det,
  input logic rd_req,
  input logic rd_valid,
  input logic wr_en
);

  // R9
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drive_low && !rd_valid) |=> scl_drive_low);

  // R9
  stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drive_low) |-> $past(rd_valid));

  // R9
  fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_valid);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_drive_low && !scl_drive_low));

  // R10
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_drive_low && !scl_drive_low));

  // R6
  commit_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(sda_drive_low));

  // R4
  port_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req));

endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
  .start_det(start_det), .stop_det(stop_det),
  .rd_req(rd_req), .rd_valid(rd_valid), .wr_en(wr_en)
);

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;

  localparam int LAT = 4;
  localparam int Q   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_line, sda_line;
  logic scl_drive_low, sda_drive_low;

  always #2 clk = ~clk;

  assign scl_line = m_scl & ~scl_drive_low;
  assign sda_line = m_sda & ~sda_drive_low;

  i2c_regslave #(.RD_LAT(LAT)) u_i2c_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  int vectors = 0, miscompares = 0, rx_bytes = 0;
  int episodes = 0, run = 0, min_run = 1000000;
  logic prev_hold = 1'b0;
  string      exp_tag_q[$];
  logic [8:0] exp_val_q[$];
  logic [8:0] obs_q[$];

  task automatic dly(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_high();
    m_scl = 1'b1;
    do dly(1); while (!scl_line);
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic i_start();
    m_sda = 1'b1; m_scl = 1'b1; dly(Q);
    m_sda = 1'b0; dly(Q);
    m_scl = 1'b0; dly(Q);
  endtask

  task automatic i_rstart();
    m_sda = 1'b1; dly(Q);
    scl_high(); dly(Q);
    m_sda = 1'b0; dly(Q);
    m_scl = 1'b0; dly(Q);
  endtask

  task automatic i_stop();
    m_sda = 1'b0; dly(Q);
    scl_high(); dly(Q);
    m_sda = 1'b1; dly(Q);
    check("R10", {7'd0, sda_drive_low, scl_drive_low}, 9'd0);
  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string tag);
    exp_tag_q.push_back(tag);
    exp_val_q.push_back({1'b1, 7'd0, exp_ack});
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; dly(Q);
      scl_high(); dly(Q);
      m_scl = 1'b0; dly(Q);
    end
    m_sda = 1'b1; dly(Q);
    scl_high(); dly(Q);
    obs_q.push_back({1'b1, 7'd0, ~sda_line});
    dly(Q);
    m_scl = 1'b0; dly(Q);
  endtask

  task automatic recv(input logic [7:0] exp_b, input logic m_ack, input string tag);
    logic [7:0] got;
    got = '0;
    exp_tag_q.push_back(tag);
    exp_val_q.push_back({1'b0, exp_b});
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      dly(Q);
      scl_high(); dly(Q);
      got = {got[6:0], sda_line};
      dly(Q);
      m_scl = 1'b0;
    end
    obs_q.push_back({1'b0, got});
    rx_bytes++;
    dly(2);
    m_sda = ~m_ack; dly(Q);
    scl_high(); dly(2 * Q);
    m_scl = 1'b0; dly(Q);
    m_sda = 1'b1;
  endtask

  task automatic rd_open(input logic [7:0] sub, input string tag);
    i_start();
    send(8'h8A, 1'b1, "R1");
    send(sub, 1'b1, tag);
    i_rstart();
    send(8'h8B, 1'b1, "R1");
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() != 0) begin
        logic [8:0] o;
        o = obs_q.pop_front();
        if (exp_val_q.size() == 0) check("scoreboard", o, 9'h1FF);
        else check(exp_tag_q.pop_front(), o, exp_val_q.pop_front());
      end
    end
  end

  // stretch episode monitor
  initial begin
    forever begin
      @(negedge clk);
      if (scl_drive_low && !prev_hold) episodes++;
      if (scl_drive_low) run++;
      else begin
        if (prev_hold && run < min_run) min_run = run;
        run = 0;
      end
      prev_hold = scl_drive_low;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL all: watchdog expired, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    dly(5);
    rst_n = 1'b1;
    dly(5);
    // R11 lines released after reset
    check("R11", {7'd0, sda_drive_low, scl_drive_low}, 9'd0);

    // R4 one-byte write and read back
    i_start(); send(8'h8A, 1'b1, "R1"); send(8'h00, 1'b1, "R3"); send(8'hA5, 1'b1, "R4"); i_stop();
    rd_open(8'h00, "R3"); recv(8'hA5, 1'b0, "R4"); i_stop();

    // R5 two-byte register, high byte first
    i_start(); send(8'h8A, 1'b1, "R1"); send(8'h10, 1'b1, "R3");
    send(8'h12, 1'b1, "R5"); send(8'h34, 1'b1, "R5"); i_stop();
    rd_open(8'h10, "R3"); recv(8'h12, 1'b1, "R5"); recv(8'h34, 1'b0, "R5"); i_stop();

    // R6 truncated two-byte write is discarded
    i_start(); send(8'h8A, 1'b1, "R1"); send(8'h10, 1'b1, "R3"); send(8'h99, 1'b1, "R6"); i_stop();
    rd_open(8'h10, "R6"); recv(8'h12, 1'b1, "R6"); recv(8'h34, 1'b0, "R6"); i_stop();

    // R7 surplus byte on a one-byte register
    i_start(); send(8'h8A, 1'b1, "R1"); send(8'h01, 1'b1, "R3");
    send(8'h5A, 1'b1, "R4"); send(8'h77, 1'b0, "R7"); i_stop();
    rd_open(8'h01, "R7"); recv(8'h5A, 1'b0, "R7"); i_stop();

    // R2 foreign address ignored until next start
    i_start(); send(8'h88, 1'b0, "R2"); send(8'h00, 1'b0, "R2"); send(8'h66, 1'b0, "R2"); i_stop();
    rd_open(8'h00, "R2"); recv(8'hA5, 1'b0, "R2"); i_stop();

    // R3 unmapped subaddress NAKed, following byte too
    i_start(); send(8'h8A, 1'b1, "R1"); send(8'h05, 1'b0, "R3"); send(8'h11, 1'b0, "R3"); i_stop();

    // R8 and R11 reset value and over-read padding
    rd_open(8'h11, "R3"); recv(8'h00, 1'b1, "R11"); recv(8'h00, 1'b1, "R11"); recv(8'hFF, 1'b0, "R8"); i_stop();

    // R10 repeated start mid-write restarts framing
    i_start(); send(8'h8A, 1'b1, "R1"); send(8'h01, 1'b1, "R3");
    i_rstart(); send(8'h8A, 1'b1, "R10"); send(8'h00, 1'b1, "R10"); send(8'h3C, 1'b1, "R10"); i_stop();
    rd_open(8'h00, "R10"); recv(8'h3C, 1'b0, "R10"); i_stop();
    rd_open(8'h01, "R10"); recv(8'h5A, 1'b0, "R10"); i_stop();

    while (exp_val_q.size() != 0 || obs_q.size() != 0) dly(1);
    // R9 one stretch per returned byte, each long enough to cover the fetch
    check("R9", 9'(episodes), 9'(rx_bytes));
    check("R9", 9'(min_run >= LAT + 1), 9'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule